// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one logic cell of a sum-of-products fabric, rebuilt as ordinary synchronous logic. It receives five precomputed product terms (AND results) and combines them according to run-time configuration inputs. A selectable subset of the terms is ORed into a sum, optionally widened by a cascade input from a neighbouring cell. The sum passes through an XOR stage whose second operand sets the polarity. A storage element then acts as a D, T, JK or SR flip-flop, or as a level latch, with a choice of clock source, an optional clock enable and level-acting clear and preset.

All cell inputs, including the global clock and every product term, are sampled on the system clock `clk`. A rising edge of the selected cell clock is the sampled level going from 0 to 1 between two consecutive `clk` edges. Each of the four outputs is registered and reflects the inputs sampled one `clk` edge earlier. Some product terms also serve fixed control roles: term 0 is the preset, term 1 the clear, term 2 the clock or clock enable, term 3 the separate data or second storage input, and term 4 the XOR operand.

Top module: `mc_macrocell`

## Requirements
- R1: `casc_out` equals, one clock later, the OR of every `pt_in` bit whose `cfg_sum_mask` bit is 1.
- R2: When `cfg_casc_en` is 1, `casc_in` is also ORed into the sum. When it is 0, `casc_in` has no effect on any output.
- R3: The combinational value is sum XOR operand. The `cfg_xor_sel` codes are 0 for constant 0, 1 for constant 1, 2 for `pt_in[4]`, and 3 for constant 0.
- R4: `cfg_d_sel` chooses the storage data. The codes are 0 for the XOR result, 1 for `pt_in[3]`, 2 for `pin_in`, and 3 for the XOR result.
- R5: `cfg_mode` selects the storage type. The codes are 0 for D and 1 for T, where T=1 toggles the stored bit. Code 2 is JK, with J the data and K `pt_in[3]`; J=K=1 toggles. Code 3 is SR, with S the data and R `pt_in[3]`; R=1 clears, so R wins over S. Codes 4 to 7 give a latch that follows the data while the cell clock level is 1 and holds while it is 0; the clock enable does not affect the latch.
- R6: `cfg_clk_sel` 0 clocks the cell from `gclk_in` and 1 from `pt_in[2]`. An edge-triggered mode updates only when the sampled clock level rises.
- R7: With `cfg_clk_sel` 0 and `cfg_ce_en` 1, a rising edge is ignored while `pt_in[2]` is 0.
- R8: `cfg_clr_sel` selects the clear. The codes are 0 for none, 1 for `gclr_in`, 2 for `pt_in[1]`, and 3 for their OR. While the clear is active the stored bit is forced to 0, ahead of all other actions.
- R9: With `cfg_pre_en` 1, `pt_in[0]` forces the stored bit to 1 unless the clear is also active.
- R10: `cfg_out_reg` 1 drives the stored bit on `pin_out` and 0 drives the combinational value. `cfg_fb_reg` chooses the same way for `fb_out`, independently of `cfg_out_reg`.
- R11: `cfg_oe_sel` sets `pin_oe`. The codes are 0 for off, 1 for on, and 2 to 7 for `goe_in[code-2]`.
- R12: While `rst` is 1 the stored bit, the last clock level and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every cell input |
| rst | input | 1 | Synchronous active-high reset |
| pt_in | input | 5 | Precomputed product-term values |
| gclk_in | input | 1 | Global cell clock level |
| gclr_in | input | 1 | Global clear level |
| goe_in | input | 6 | Global output enables |
| casc_in | input | 1 | Sum from the neighbouring cell |
| pin_in | input | 1 | Value present at the pin |
| cfg_sum_mask | input | 5 | Product terms that feed the sum |
| cfg_casc_en | input | 1 | Add the cascade input to the sum |
| cfg_xor_sel | input | 2 | XOR operand code |
| cfg_d_sel | input | 2 | Storage data source code |
| cfg_mode | input | 3 | Storage type code |
| cfg_clk_sel | input | 1 | Cell clock source |
| cfg_ce_en | input | 1 | Use term 2 as clock enable |
| cfg_clr_sel | input | 2 | Clear source code |
| cfg_pre_en | input | 1 | Enable preset from term 0 |
| cfg_out_reg | input | 1 | Pin shows stored bit (1) or logic (0) |
| cfg_fb_reg | input | 1 | Feedback shows stored bit (1) or logic (0) |
| cfg_oe_sel | input | 3 | Output enable code |
| pin_out | output | 1 | Pin value |
| pin_oe | output | 1 | Pin drive enable |
| fb_out | output | 1 | Feedback to the routing |
| casc_out | output | 1 | Sum offered to the next cell |

## Verification
Some properties are checked on every cycle. A clear leaves the stored bit at 0, and a preset without a clear leaves it at 1. A disabled clock edge holds the stored bit, and a T edge with T=1 inverts it. A register-selected pin or feedback shows the stored bit, code 0 keeps the pin undriven, and reset zeroes the outputs. Other behaviours appear only in the bench's scenarios against its own model: the JK and SR truth tables, latch transparency, the cascade, the XOR polarities, the data source choices and the global enable mapping.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam logic [1:0] XOP_ZERO = 2'd0;
  localparam logic [1:0] XOP_ONE  = 2'd1;
  localparam logic [1:0] XOP_TERM = 2'd2;

  localparam logic [1:0] DSRC_XOR  = 2'd0;
  localparam logic [1:0] DSRC_TERM = 2'd1;
  localparam logic [1:0] DSRC_PIN  = 2'd2;

  localparam logic [1:0] STOR_D  = 2'd0;
  localparam logic [1:0] STOR_T  = 2'd1;
  localparam logic [1:0] STOR_JK = 2'd2;
  localparam logic [1:0] STOR_SR = 2'd3;

  // role of each product term inside the cell
  localparam int TERM_PRE = 0;
  localparam int TERM_CLR = 1;
  localparam int TERM_CLK = 2;
  localparam int TERM_DAT = 3;
  localparam int TERM_XOP = 4;
endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
  parameter int NPT = 5
) (
  input  logic [NPT-1:0] pt,
  input  logic [NPT-1:0] mask,
  input  logic           casc_en,
  input  logic           casc_in,
  input  logic [1:0]     xor_sel,
  input  logic           xor_term,
  output logic           sum_o,
  output logic           x_o
);
  import mc_pkg::*;

  logic [NPT-1:0] gated;
  logic           operand;

  genvar gi;
  generate
    for (gi = 0; gi < NPT; gi++) begin : g_gate
      assign gated[gi] = pt[gi] & mask[gi];
    end
  endgenerate

  always_comb begin
    sum_o = (|gated) | (casc_en & casc_in);
    unique case (xor_sel)
      XOP_ONE:  operand = 1'b1;
      XOP_TERM: operand = xor_term;
      default:  operand = 1'b0;
    endcase
    x_o = sum_o ^ operand;
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic       clk,
  input  logic       rst,
  input  logic       gclk,
  input  logic       gclr,
  input  logic       term_clk,
  input  logic       term_clr,
  input  logic       term_pre,
  input  logic       term_dat,
  input  logic       x_val,
  input  logic       pin_in,
  input  logic [1:0] d_sel,
  input  logic [2:0] mode,
  input  logic       clk_sel,
  input  logic       ce_en,
  input  logic [1:0] clr_sel,
  input  logic       pre_en,
  output logic       q_next_o,
  output logic       q_o
);
  import mc_pkg::*;

  logic q_r, lvl_prev;
  logic lvl, rise, ce, clr_act, pre_act, d, edge_val;

  always_comb begin
    lvl     = clk_sel ? term_clk : gclk;
    rise    = lvl & ~lvl_prev;
    ce      = (!clk_sel && ce_en) ? term_clk : 1'b1;
    clr_act = (clr_sel[0] & gclr) | (clr_sel[1] & term_clr);
    pre_act = pre_en & term_pre;
    unique case (d_sel)
      DSRC_TERM: d = term_dat;
      DSRC_PIN:  d = pin_in;
      default:   d = x_val;
    endcase
    unique case (mode[1:0])
      STOR_T:  edge_val = q_r ^ d;
      STOR_JK: edge_val = (d & ~q_r) | (~term_dat & q_r);
      STOR_SR: edge_val = term_dat ? 1'b0 : (d | q_r);
      default: edge_val = d;
    endcase
    if (clr_act)          q_next_o = 1'b0;
    else if (pre_act)     q_next_o = 1'b1;
    else if (mode[2])     q_next_o = lvl ? d : q_r;
    else if (rise && ce)  q_next_o = edge_val;
    else                  q_next_o = q_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r      <= 1'b0;
      lvl_prev <= 1'b0;
    end else begin
      q_r      <= q_next_o;
      lvl_prev <= lvl;
    end
  end

  assign q_o = q_r;

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (q_r == 1'b0)) else $error("clear did not force 0");

  assert_preset_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (pre_act && !clr_act) |=> q_r) else $error("preset did not force 1");

  assert_ce_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (!clk_sel && ce_en && !term_clk && !mode[2] && !clr_act && !pre_act) |=> $stable(q_r))
    else $error("disabled edge changed state");

  assert_t_toggles_R5: assert property (@(posedge clk) disable iff (rst)
    (!mode[2] && mode[1:0] == STOR_T && rise && ce && d && !clr_act && !pre_act)
      |=> (q_r != $past(q_r))) else $error("T edge did not toggle");
endmodule

// File: rtl/mc_outsel.sv
module mc_outsel #(
  parameter int NGOE = 6,
  parameter int OE_W = $clog2(NGOE + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            q_next,
  input  logic            x_val,
  input  logic            sum,
  input  logic [NGOE-1:0] goe,
  input  logic            out_reg,
  input  logic            fb_reg,
  input  logic [OE_W-1:0] oe_sel,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb_out,
  output logic            casc_out
);
  localparam int NCODE = 1 << OE_W;

  logic [NCODE-1:0] oe_cand;

  genvar gi;
  generate
    for (gi = 0; gi < NCODE; gi++) begin : g_oe
      if (gi == 0) begin : g_off
        assign oe_cand[gi] = 1'b0;
      end else if (gi == 1) begin : g_on
        assign oe_cand[gi] = 1'b1;
      end else if (gi < NGOE + 2) begin : g_glob
        assign oe_cand[gi] = goe[gi-2];
      end else begin : g_spare
        assign oe_cand[gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out  <= 1'b0;
      pin_oe   <= 1'b0;
      fb_out   <= 1'b0;
      casc_out <= 1'b0;
    end else begin
      pin_out  <= out_reg ? q_next : x_val;
      fb_out   <= fb_reg  ? q_next : x_val;
      pin_oe   <= oe_cand[oe_sel];
      casc_out <= sum;
    end
  end

  assert_oe_off_R11: assert property (@(posedge clk) disable iff (rst)
    (oe_sel == '0) |=> !pin_oe) else $error("pin driven while off");

  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (!pin_out && !pin_oe && !fb_out && !casc_out)) else $error("outputs not cleared");
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
  parameter int NPT  = 5,
  parameter int NGOE = 6,
  localparam int OE_W = $clog2(NGOE + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPT-1:0]  pt_in,
  input  logic            gclk_in,
  input  logic            gclr_in,
  input  logic [NGOE-1:0] goe_in,
  input  logic            casc_in,
  input  logic            pin_in,
  input  logic [NPT-1:0]  cfg_sum_mask,
  input  logic            cfg_casc_en,
  input  logic [1:0]      cfg_xor_sel,
  input  logic [1:0]      cfg_d_sel,
  input  logic [2:0]      cfg_mode,
  input  logic            cfg_clk_sel,
  input  logic            cfg_ce_en,
  input  logic [1:0]      cfg_clr_sel,
  input  logic            cfg_pre_en,
  input  logic            cfg_out_reg,
  input  logic            cfg_fb_reg,
  input  logic [OE_W-1:0] cfg_oe_sel,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb_out,
  output logic            casc_out
);
  import mc_pkg::*;

  logic sum_w, x_w, q_next_w, q_w;

  mc_sum #(.NPT(NPT)) u_sum (
    .pt       (pt_in),
    .mask     (cfg_sum_mask),
    .casc_en  (cfg_casc_en),
    .casc_in  (casc_in),
    .xor_sel  (cfg_xor_sel),
    .xor_term (pt_in[TERM_XOP]),
    .sum_o    (sum_w),
    .x_o      (x_w)
  );

  mc_store u_store (
    .clk      (clk),
    .rst      (rst),
    .gclk     (gclk_in),
    .gclr     (gclr_in),
    .term_clk (pt_in[TERM_CLK]),
    .term_clr (pt_in[TERM_CLR]),
    .term_pre (pt_in[TERM_PRE]),
    .term_dat (pt_in[TERM_DAT]),
    .x_val    (x_w),
    .pin_in   (pin_in),
    .d_sel    (cfg_d_sel),
    .mode     (cfg_mode),
    .clk_sel  (cfg_clk_sel),
    .ce_en    (cfg_ce_en),
    .clr_sel  (cfg_clr_sel),
    .pre_en   (cfg_pre_en),
    .q_next_o (q_next_w),
    .q_o      (q_w)
  );

  mc_outsel #(.NGOE(NGOE)) u_out (
    .clk      (clk),
    .rst      (rst),
    .q_next   (q_next_w),
    .x_val    (x_w),
    .sum      (sum_w),
    .goe      (goe_in),
    .out_reg  (cfg_out_reg),
    .fb_reg   (cfg_fb_reg),
    .oe_sel   (cfg_oe_sel),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_out   (fb_out),
    .casc_out (casc_out)
  );

  assert_pin_stored_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_out_reg |=> (pin_out == q_w)) else $error("registered pin differs from state");

  assert_fb_stored_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_fb_reg |=> (fb_out == q_w)) else $error("registered feedback differs from state");
endmodule

// File: tb/sim_mc_macrocell.sv
`timescale 1ns/1ps
module sim_mc_macrocell;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic [4:0] pt_in = '0;
  logic gclk_in = 0, gclr_in = 0, casc_in = 0, pin_in = 0;
  logic [5:0] goe_in = '0;
  logic [4:0] cfg_sum_mask = '0;
  logic cfg_casc_en = 0, cfg_clk_sel = 0, cfg_ce_en = 0, cfg_pre_en = 0;
  logic cfg_out_reg = 0, cfg_fb_reg = 0;
  logic [1:0] cfg_xor_sel = '0, cfg_d_sel = '0, cfg_clr_sel = '0;
  logic [2:0] cfg_mode = '0, cfg_oe_sel = '0;
  logic pin_out, pin_oe, fb_out, casc_out;

  mc_macrocell u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit mq = 0, mprev = 0;
  logic e_pin, e_oe, e_fb, e_casc;
  string st_tag, sum_tag;

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic predict();
    logic sum, op, x, d, lvl, go, clr, pre, nq;
    sum = (|(pt_in & cfg_sum_mask)) || (cfg_casc_en && casc_in);
    op = (cfg_xor_sel == 2'd1) ? 1'b1 : (cfg_xor_sel == 2'd2) ? pt_in[4] : 1'b0;
    x = sum ^ op;
    d = (cfg_d_sel == 2'd1) ? pt_in[3] : (cfg_d_sel == 2'd2) ? pin_in : x;
    lvl = cfg_clk_sel ? pt_in[2] : gclk_in;
    go = lvl && !mprev && (cfg_clk_sel || !cfg_ce_en || pt_in[2]);
    case (cfg_clr_sel)
      2'd1: clr = gclr_in;
      2'd2: clr = pt_in[1];
      2'd3: clr = gclr_in || pt_in[1];
      default: clr = 1'b0;
    endcase
    pre = cfg_pre_en && pt_in[0];
    nq = mq;
    if (clr) nq = 1'b0;
    else if (pre) nq = 1'b1;
    else if (cfg_mode >= 3'd4) begin if (lvl) nq = d; end
    else if (go) begin
      case (cfg_mode)
        3'd0: nq = d;
        3'd1: nq = d ? !mq : mq;
        3'd2: case ({d, pt_in[3]})
                2'b01: nq = 1'b0;
                2'b10: nq = 1'b1;
                2'b11: nq = !mq;
                default: nq = mq;
              endcase
        default: nq = pt_in[3] ? 1'b0 : (d ? 1'b1 : mq);
      endcase
    end
    if (clr) st_tag = "R8";
    else if (pre) st_tag = "R9";
    else if (cfg_mode >= 3'd4) st_tag = "R5";
    else if (cfg_clk_sel) st_tag = "R6";
    else if (cfg_ce_en) st_tag = "R7";
    else if (cfg_d_sel != 2'd0) st_tag = "R4";
    else st_tag = "R5";
    if (!cfg_out_reg || !cfg_fb_reg) st_tag = {st_tag, " R3"};
    sum_tag = cfg_casc_en ? "R2" : "R1";
    e_oe = (cfg_oe_sel == 3'd0) ? 1'b0 : (cfg_oe_sel == 3'd1) ? 1'b1 : goe_in[cfg_oe_sel - 3'd2];
    e_pin = cfg_out_reg ? nq : x;
    e_fb = cfg_fb_reg ? nq : x;
    e_casc = sum;
    if (rst) begin
      nq = 1'b0; lvl = 1'b0;
      e_oe = 0; e_pin = 0; e_fb = 0; e_casc = 0;
      st_tag = "R12"; sum_tag = "R12";
    end
    mq = nq;
    mprev = lvl;
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    check({"R10 ", st_tag, " pin_out"}, pin_out, e_pin);
    check({"R10 ", st_tag, " fb_out"}, fb_out, e_fb);
    check(rst ? "R12 pin_oe" : "R11 pin_oe", pin_oe, e_oe);
    check({sum_tag, " casc_out"}, casc_out, e_casc);
  endtask

  task automatic rand_cfg();
    cfg_sum_mask = 5'($urandom);
    cfg_casc_en = 1'($urandom);
    cfg_xor_sel = 2'($urandom);
    cfg_d_sel = 2'($urandom);
    cfg_mode = 3'($urandom);
    cfg_clk_sel = 1'($urandom);
    cfg_ce_en = 1'($urandom);
    cfg_clr_sel = 2'($urandom);
    cfg_pre_en = 1'($urandom);
    cfg_out_reg = 1'($urandom);
    cfg_fb_reg = 1'($urandom);
    cfg_oe_sel = 3'($urandom);
  endtask

  task automatic rand_inputs();
    pt_in[4:2] = 3'($urandom);
    pt_in[1] = ($urandom % 5 == 0);
    pt_in[0] = ($urandom % 5 == 0);
    if ($urandom % 2 == 0) gclk_in = ~gclk_in;
    gclr_in = ($urandom % 6 == 0);
    goe_in = 6'($urandom);
    casc_in = 1'($urandom);
    pin_in = 1'($urandom);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R12: reset holds everything low even with active inputs
    @(negedge clk);
    pt_in = 5'h1F; gclk_in = 1; cfg_oe_sel = 3'd1; cfg_out_reg = 1; cfg_sum_mask = 5'h1F;
    step();
    step();
    rst = 1'b0;
    pt_in = '0; gclk_in = 0;
    // R5: JK mode, J=K=1 toggles on each global edge
    cfg_mode = 3'd2; cfg_d_sel = 2'd0; cfg_sum_mask = 5'b00100 ^ 5'b00100; cfg_xor_sel = 2'd1;
    cfg_out_reg = 1; cfg_fb_reg = 1;
    pt_in[3] = 1;
    for (int i = 0; i < 6; i++) begin gclk_in = ~gclk_in; step(); end
    // R8/R9: clear and preset together, clear wins
    cfg_clr_sel = 2'd1; cfg_pre_en = 1; gclr_in = 1; pt_in[0] = 1;
    step();
    gclr_in = 0;
    step();
    pt_in[0] = 0; cfg_pre_en = 0; cfg_clr_sel = 2'd0;
    // R7: clock enable low blocks edges in D mode
    cfg_mode = 3'd0; cfg_ce_en = 1; pt_in[2] = 0; cfg_xor_sel = 2'd0;
    for (int i = 0; i < 4; i++) begin gclk_in = ~gclk_in; step(); end
    // R5: latch follows data while product-term clock is high
    cfg_mode = 3'd4; cfg_clk_sel = 1; cfg_d_sel = 2'd2;
    pt_in[2] = 1;
    for (int i = 0; i < 4; i++) begin pin_in = ~pin_in; step(); end
    pt_in[2] = 0;
    for (int i = 0; i < 3; i++) begin pin_in = ~pin_in; step(); end
    // R2: cascade ignored when disabled
    cfg_casc_en = 0; cfg_sum_mask = '0; pt_in = '0;
    casc_in = 1; step();
    cfg_casc_en = 1; step();
    // R11: every global enable code
    for (int c = 2; c < 8; c++) begin
      cfg_oe_sel = 3'(c); goe_in = 6'(1 << (c - 2)); step();
      goe_in = ~goe_in; step();
    end
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      if (n % 16 == 0) rand_cfg();
      rand_inputs();
      step();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule